// File: doc/BRIEF.md
# Multiplexed Vacuum Fluorescent Display Grid Scanner

This block time-shares one set of anode lines among several digit positions of a multiplexed vacuum fluorescent display. It turns on exactly one grid at a time, puts the segment pattern of that digit on the anode bus, and steps through every grid in a repeating frame. Each digit slot opens with a blanking phase in which the grid stays off while the anodes already carry the new pattern. This keeps slow-decaying grid pulses from lighting segments of the next digit. A grid-on window follows, and its length sets the brightness. Any remainder of the slot is dark.

Software-facing state is limited to a small write port into a per-digit pattern array and three live configuration inputs: slot length, blanking length and dimming level. The slot length is counted in ticks of an internal prescaler derived from `CLK_HZ / TICK_HZ`. The block samples the configuration and the pattern array only at a frame boundary, so a digit never shows a mix of old and new settings. It also clamps the slot length so that the full-frame rate stays at or above `MIN_SCAN_HZ` and outside the 250 Hz to 500 Hz band.

The scan state machine has four states. ST_LOAD is held in reset and left after one cycle. ST_BLANK is the blanking phase, ST_ON is the grid-on window and ST_DARK is the dimmed remainder. The transitions are:
- LOAD→BLANK, one cycle after reset.
- BLANK→ON when the blanking has elapsed.
- BLANK→DARK when the window is empty.
- ON→DARK when the window has elapsed below full brightness.
- Any state→BLANK at slot end, which also advances the digit index and, after the last digit, reloads the frame.

Top module: `vfd_scan_ctrl`

## Requirements
- R1: `grid_o` is active high and has at most one bit set at any time. Bit k enables digit position k.
- R2: While a grid is on, `anode_o` carries the pattern held for that digit position (active high, bit i = segment i).
- R3: Digits are scanned in the order 0, 1, …, N_GRID−1, and the order then repeats. Consecutive grid pulses start exactly slot×PRE clock cycles apart, where PRE = CLK_HZ/TICK_HZ and slot is the clamped slot length. A grid never hands over directly to another grid without an all-off cycle in between.
- R4: Each slot begins with blank ticks during which every grid is off. The anode bus loads the new digit's pattern at the first clock of the slot, so a grid rises exactly blank×PRE cycles after its anode pattern appeared. A blanking request is clamped to the range 1 … slot−1.
- R5: The grid-on window lasts on = ⌊(slot−blank)×dim/(2^DIM_W−1)⌋ ticks. With dim = 0 no grid ever turns on.
- R6: A slot request below 2 becomes 2. A request above SLOT_MAX = ⌊TICK_HZ/(MIN_SCAN_HZ×N_GRID)⌋ becomes SLOT_MAX. A request from ⌊TICK_HZ/(500×N_GRID)⌋ through ⌊TICK_HZ/(250×N_GRID)⌋ becomes the upper band limit plus one.
- R7: Pattern writes and configuration changes take effect only at the start of a frame, after the slot of digit N_GRID−1 ends. Slots that remain in the current frame keep the old values.
- R8: While `rst_n` is low, `grid_o` and `anode_o` are all zeros. The first grid to turn on after reset is digit 0.
- R9: A write whose address is N_GRID or above changes no digit pattern.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dig_wr_en | input | 1 | Write strobe for the digit pattern array |
| dig_wr_addr | input | ADDR_W | Digit position to write |
| dig_wr_data | input | SEG_W | Segment pattern to store |
| slot_len_i | input | CNT_W | Requested slot length in ticks |
| blank_len_i | input | CNT_W | Requested blanking length in ticks |
| dim_i | input | DIM_W | Brightness level, all ones = full |
| grid_o | output | N_GRID | One-hot grid enables, active high |
| anode_o | output | SEG_W | Segment drive for the enabled digit, active high |

## Verification
The bench measures timing from the pins rather than from state. It times each grid rise against the most recent anode change and against the previous grid rise, and it times each grid's high width. A design that blanked the anodes along with the grid, or switched the anodes late, would show a blanking offset other than blank×PRE. A wrong clamp shows up as a wrong pulse period. The directed runs cover slot requests at 1, at both band edges, inside the band and beyond the minimum scan rate, as well as a zero blanking request, a blanking request larger than the slot, and a dimming level of zero. A design that skipped the dimming check would light a grid when dim is zero. One test rewrites the patterns and the configuration while digit 0 is lit. A design that let these through mid-frame would show the new pattern or timing on digits 1 to N_GRID−1 of that same frame.

// File: rtl/vfd_scan_pkg.sv
package vfd_scan_pkg;

    // Phases of the digit slot scanner.
    typedef enum logic [1:0] {
        ST_LOAD  = 2'd0,
        ST_BLANK = 2'd1,
        ST_ON    = 2'd2,
        ST_DARK  = 2'd3
    } scan_state_e;

endpackage

// File: rtl/vfd_tick_gen.sv
module vfd_tick_gen #(
    parameter int PRE_DIV = 50
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick_o
);
    localparam int CW = (PRE_DIV > 1) ? $clog2(PRE_DIV) : 1;

    logic [CW-1:0] cnt_q;

    assign tick_o = (cnt_q == CW'(PRE_DIV - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (tick_o) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    generate
        if (PRE_DIV > 1) begin : g_gap
            // R3: ticks are spaced, never back to back when dividing
            a_r3_tick_gap: assert property (@(posedge clk) disable iff (!rst_n)
                tick_o |=> !tick_o);
        end
    endgenerate

endmodule

// File: rtl/vfd_cfg_snap.sv
module vfd_cfg_snap #(
    parameter int CNT_W    = 12,
    parameter int DIM_W    = 4,
    parameter int SLOT_MAX = 1250,
    parameter int BAND_LO  = 250,
    parameter int BAND_HI  = 500
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] slot_req_i,
    input  logic [CNT_W-1:0] blank_req_i,
    input  logic [DIM_W-1:0] dim_req_i,
    output logic [CNT_W-1:0] slot_o,
    output logic [CNT_W-1:0] blank_o,
    output logic [CNT_W-1:0] on_o
);
    localparam int SLOT_MIN = 2;
    localparam int BAND_FIX = (BAND_HI + 1 > SLOT_MAX) ? SLOT_MAX : BAND_HI + 1;
    localparam int PW       = CNT_W + DIM_W;
    localparam logic [PW-1:0] DIM_FULL = PW'((1 << DIM_W) - 1);

    logic [CNT_W-1:0] slot_c, blank_c, span_c, on_c;
    logic [PW-1:0]    prod_c;

    // Slot clamp: floor, minimum scan rate, forbidden band.
    always_comb begin
        if (slot_req_i < CNT_W'(SLOT_MIN)) begin
            slot_c = CNT_W'(SLOT_MIN);
        end else if (slot_req_i > CNT_W'(SLOT_MAX)) begin
            slot_c = CNT_W'(SLOT_MAX);
        end else if (slot_req_i >= CNT_W'(BAND_LO) && slot_req_i <= CNT_W'(BAND_HI)) begin
            slot_c = CNT_W'(BAND_FIX);
        end else begin
            slot_c = slot_req_i;
        end
    end

    // Blanking needs at least one tick and must leave one tick of slot.
    always_comb begin
        if (blank_req_i == '0) begin
            blank_c = CNT_W'(1);
        end else if (blank_req_i > slot_c - CNT_W'(1)) begin
            blank_c = slot_c - CNT_W'(1);
        end else begin
            blank_c = blank_req_i;
        end
        span_c = slot_c - blank_c;
        prod_c = {{DIM_W{1'b0}}, span_c} * {{CNT_W{1'b0}}, dim_req_i};
        on_c   = CNT_W'(prod_c / DIM_FULL);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            slot_o  <= CNT_W'(SLOT_MIN);
            blank_o <= CNT_W'(1);
            on_o    <= '0;
        end else if (load_i) begin
            slot_o  <= slot_c;
            blank_o <= blank_c;
            on_o    <= on_c;
        end
    end

    // R6: an applied slot is always a legal length
    a_r6_slot_legal: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_o >= CNT_W'(SLOT_MIN)) && (slot_o <= CNT_W'(SLOT_MAX)) &&
        !((slot_o >= CNT_W'(BAND_LO)) && (slot_o <= CNT_W'(BAND_HI))));

    // R4/R5: blanking and window fit inside the slot
    a_r5_window_fits: assert property (@(posedge clk) disable iff (!rst_n)
        (blank_o >= CNT_W'(1)) && ({1'b0, blank_o} + {1'b0, on_o} <= {1'b0, slot_o}));

endmodule

// File: rtl/vfd_digit_store.sv
module vfd_digit_store #(
    parameter int N_GRID = 8,
    parameter int SEG_W  = 8,
    parameter int ADDR_W = 4,
    parameter int IDX_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [SEG_W-1:0]  wr_data,
    input  logic              load_i,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [SEG_W-1:0]  pat_o
);
    logic [SEG_W-1:0] live_q  [N_GRID];
    logic [SEG_W-1:0] shown_q [N_GRID];

    generate
        for (genvar k = 0; k < N_GRID; k++) begin : g_digit
            logic hit;
            assign hit = wr_en && (wr_addr == ADDR_W'(k));

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    live_q[k]  <= '0;
                    shown_q[k] <= '0;
                end else begin
                    if (hit) begin
                        live_q[k] <= wr_data;
                    end
                    if (load_i) begin
                        shown_q[k] <= live_q[k];
                    end
                end
            end
        end
    endgenerate

    assign pat_o = shown_q[rd_idx];

endmodule

// File: rtl/vfd_scan_ctrl.sv
module vfd_scan_ctrl
    import vfd_scan_pkg::*;
#(
    parameter int N_GRID      = 8,
    parameter int SEG_W       = 8,
    parameter int CNT_W       = 12,
    parameter int DIM_W       = 4,
    parameter int CLK_HZ      = 50_000_000,
    parameter int TICK_HZ     = 1_000_000,
    parameter int MIN_SCAN_HZ = 100,
    parameter int ADDR_W      = $clog2(N_GRID) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dig_wr_en,
    input  logic [ADDR_W-1:0] dig_wr_addr,
    input  logic [SEG_W-1:0]  dig_wr_data,
    input  logic [CNT_W-1:0]  slot_len_i,
    input  logic [CNT_W-1:0]  blank_len_i,
    input  logic [DIM_W-1:0]  dim_i,
    output logic [N_GRID-1:0] grid_o,
    output logic [SEG_W-1:0]  anode_o
);
    localparam int IDX_W    = (N_GRID > 1) ? $clog2(N_GRID) : 1;
    localparam int PRE_DIV  = (CLK_HZ / TICK_HZ > 0) ? CLK_HZ / TICK_HZ : 1;
    localparam int SLOT_MAX = TICK_HZ / (MIN_SCAN_HZ * N_GRID);
    localparam int BAND_LO  = TICK_HZ / (500 * N_GRID);
    localparam int BAND_HI  = TICK_HZ / (250 * N_GRID);

    scan_state_e      state_q, state_d;
    logic [IDX_W-1:0] idx_q, idx_d;
    logic [CNT_W-1:0] pos_q, pos_d;
    logic [CNT_W-1:0] slot_q, blank_q, on_q;
    logic [CNT_W:0]   pos_inc, on_end;
    logic [SEG_W-1:0] pat;
    logic             tick, last_pos, last_idx, frame_load;

    vfd_tick_gen #(.PRE_DIV(PRE_DIV)) u_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_o (tick)
    );

    vfd_cfg_snap #(
        .CNT_W    (CNT_W),
        .DIM_W    (DIM_W),
        .SLOT_MAX (SLOT_MAX),
        .BAND_LO  (BAND_LO),
        .BAND_HI  (BAND_HI)
    ) u_cfg (
        .clk         (clk),
        .rst_n       (rst_n),
        .load_i      (frame_load),
        .slot_req_i  (slot_len_i),
        .blank_req_i (blank_len_i),
        .dim_req_i   (dim_i),
        .slot_o      (slot_q),
        .blank_o     (blank_q),
        .on_o        (on_q)
    );

    vfd_digit_store #(
        .N_GRID (N_GRID),
        .SEG_W  (SEG_W),
        .ADDR_W (ADDR_W),
        .IDX_W  (IDX_W)
    ) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (dig_wr_en),
        .wr_addr (dig_wr_addr),
        .wr_data (dig_wr_data),
        .load_i  (frame_load),
        .rd_idx  (idx_q),
        .pat_o   (pat)
    );

    assign last_pos   = (pos_q == slot_q - CNT_W'(1));
    assign last_idx   = (idx_q == IDX_W'(N_GRID - 1));
    assign pos_inc    = {1'b0, pos_q} + 1'b1;
    assign on_end     = {1'b0, blank_q} + {1'b0, on_q};
    assign frame_load = (state_q == ST_LOAD) ||
                        ((state_q != ST_LOAD) && tick && last_pos && last_idx);

    // Next state, digit index and slot position.
    always_comb begin
        state_d = state_q;
        idx_d   = idx_q;
        pos_d   = pos_q;
        unique case (state_q)
            ST_LOAD: begin
                state_d = ST_BLANK;
                idx_d   = '0;
                pos_d   = '0;
            end
            ST_BLANK, ST_ON, ST_DARK: begin
                if (tick) begin
                    if (last_pos) begin
                        state_d = ST_BLANK;
                        pos_d   = '0;
                        idx_d   = last_idx ? '0 : idx_q + 1'b1;
                    end else begin
                        pos_d = pos_inc[CNT_W-1:0];
                        if (pos_inc < {1'b0, blank_q}) begin
                            state_d = ST_BLANK;
                        end else if (pos_inc < on_end) begin
                            state_d = ST_ON;
                        end else begin
                            state_d = ST_DARK;
                        end
                    end
                end
            end
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_LOAD;
            idx_q   <= '0;
            pos_q   <= '0;
        end else begin
            state_q <= state_d;
            idx_q   <= idx_d;
            pos_q   <= pos_d;
        end
    end

    // Outputs decoded from the registered state.
    always_comb begin
        grid_o  = '0;
        anode_o = '0;
        if (state_q == ST_ON) begin
            grid_o[idx_q] = 1'b1;
        end
        if (state_q != ST_LOAD) begin
            anode_o = pat;
        end
    end

    // R1: at most one grid lit
    a_r1_grid_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grid_o));

    // R2: anode pattern is frozen while a grid stays lit
    a_r2_anode_steady: assert property (@(posedge clk) disable iff (!rst_n)
        (grid_o != '0 && $past(grid_o) != '0) |-> (anode_o == $past(anode_o)));

    // R3: no direct hand-over from one grid to another
    a_r3_no_direct_switch: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(grid_o) != '0 && grid_o != $past(grid_o)) |-> (grid_o == '0));

    // R4: anodes only reload while every grid is dark
    a_r4_anode_switch_dark: assert property (@(posedge clk) disable iff (!rst_n)
        (anode_o != $past(anode_o)) |-> (grid_o == '0));

    // R4: a grid never lights in the same cycle its pattern arrives
    a_r4_rise_after_load: assert property (@(posedge clk) disable iff (!rst_n)
        (grid_o != '0 && $past(grid_o) == '0) |-> (anode_o == $past(anode_o)));

endmodule

// File: tb/vfd_scan_ctrl_tb.sv
module vfd_scan_ctrl_tb;
    localparam int N     = 5;
    localparam int SW    = 8;
    localparam int CW    = 8;
    localparam int DW    = 4;
    localparam int AW    = 4;
    localparam int CLKHZ = 80000;
    localparam int TKHZ  = 40000;
    localparam int MINHZ = 100;
    localparam int PRE   = CLKHZ / TKHZ;
    localparam int SMAX  = TKHZ / (MINHZ * N);
    localparam int BLO   = TKHZ / (500 * N);
    localparam int BHI   = TKHZ / (250 * N);
    localparam int DMAX  = (1 << DW) - 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          dig_wr_en = 1'b0;
    logic [AW-1:0] dig_wr_addr = '0;
    logic [SW-1:0] dig_wr_data = '0;
    logic [CW-1:0] slot_len_i = '0;
    logic [CW-1:0] blank_len_i = '0;
    logic [DW-1:0] dim_i = '0;
    logic [N-1:0]  grid_o;
    logic [SW-1:0] anode_o;

    always #5 clk = ~clk;

    vfd_scan_ctrl #(
        .N_GRID (N), .SEG_W (SW), .CNT_W (CW), .DIM_W (DW),
        .CLK_HZ (CLKHZ), .TICK_HZ (TKHZ), .MIN_SCAN_HZ (MINHZ), .ADDR_W (AW)
    ) u_dut (
        .clk (clk), .rst_n (rst_n),
        .dig_wr_en (dig_wr_en), .dig_wr_addr (dig_wr_addr), .dig_wr_data (dig_wr_data),
        .slot_len_i (slot_len_i), .blank_len_i (blank_len_i), .dim_i (dim_i),
        .grid_o (grid_o), .anode_o (anode_o)
    );

    int unsigned n_chk = 0;
    int unsigned n_fail = 0;
    longint      cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    logic [N-1:0]  grid_s = '0, prev_g = '0;
    logic [SW-1:0] last_an = '0;
    longint        cyc_s = 0, t_chg = 0, t_prev = 0;
    bit            have_prev = 0;
    logic [SW-1:0] pat_exp [N];
    logic [SW-1:0] pat_new [N];

    task automatic check_eq(string req, string what, longint act, longint exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int f_slot(int s);
        if (s < 2) return 2;
        if (s > SMAX) return SMAX;
        if (s >= BLO && s <= BHI) return BHI + 1;
        return s;
    endfunction

    function automatic int f_blank(int b, int s);
        if (b < 1) return 1;
        if (b > s - 1) return s - 1;
        return b;
    endfunction

    function automatic int f_on(int s, int b, int d);
        return ((s - b) * d) / DMAX;
    endfunction

    task automatic step();
        prev_g = grid_s;
        @(negedge clk);
        grid_s = grid_o;
        cyc_s  = cyc;
        if (anode_o != last_an) begin
            last_an = anode_o;
            t_chg   = cyc_s;
        end
    endtask

    task automatic wr_dig(int a, logic [SW-1:0] v);
        dig_wr_en   = 1'b1;
        dig_wr_addr = AW'(a);
        dig_wr_data = v;
        step();
        dig_wr_en   = 1'b0;
    endtask

    task automatic wait_rise(int k);
        do step(); while (!(grid_s[k] && !prev_g[k]));
    endtask

    task automatic measure_slot(int k, int s, int b, int o, logic [SW-1:0] p, bit per);
        longint t_r;
        wait_rise(k);
        t_r = cyc_s;
        check_eq("R1", $sformatf("grid bus for digit %0d", k), longint'(grid_s), longint'(1) << k);
        check_eq("R2", $sformatf("anode for digit %0d", k), longint'(anode_o), longint'(p));
        check_eq("R4", $sformatf("blank gap digit %0d", k), t_r - t_chg, longint'(b * PRE));
        if (per && have_prev)
            check_eq("R3", $sformatf("pulse period into digit %0d", k), t_r - t_prev, longint'(s * PRE));
        t_prev    = t_r;
        have_prev = 1;
        do step(); while (grid_s[k]);
        check_eq("R5", $sformatf("on width digit %0d", k), cyc_s - t_r, longint'(o * PRE));
    endtask

    task automatic measure_frame(int s, int b, int o);
        wait_rise(N - 1);
        have_prev = 0;
        for (int k = 0; k < N; k++) measure_slot(k, s, b, o, pat_exp[k], k > 0);
    endtask

    task automatic new_pats();
        for (int k = 0; k < N; k++) pat_new[k] = {5'($urandom), 3'(k)};
    endtask

    task automatic load_pats();
        for (int k = 0; k < N; k++) wr_dig(k, pat_new[k]);
        for (int k = 0; k < N; k++) pat_exp[k] = pat_new[k];
    endtask

    task automatic run_cfg(int s, int b, int d);
        int es, eb, eo;
        slot_len_i  = CW'(s);
        blank_len_i = CW'(b);
        dim_i       = DW'(d);
        es = f_slot(s);
        eb = f_blank(b, es);
        eo = f_on(es, eb, d);
        wait_rise(0);
        measure_frame(es, eb, eo);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_fail++;
        n_chk++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        int cnt;
        void'($urandom(32'd4242));
        slot_len_i  = CW'(12);
        blank_len_i = CW'(3);
        dim_i       = DW'(DMAX);
        repeat (3) @(negedge clk);
        // R8: quiet outputs during reset
        check_eq("R8", "grid in reset", longint'(grid_o), 0);
        check_eq("R8", "anode in reset", longint'(anode_o), 0);
        rst_n = 1'b1;
        do step(); while (grid_s == '0);
        check_eq("R8", "first grid after reset", longint'(grid_s), 1);

        // Baseline frame, full brightness
        new_pats();
        load_pats();
        run_cfg(12, 3, DMAX);

        // R6: slot clamps (floor, band edges, inside band, above min rate)
        run_cfg(1, 1, DMAX);
        run_cfg(BLO - 1, 2, DMAX);
        run_cfg(BLO, 2, DMAX);
        run_cfg(20, 2, DMAX);
        run_cfg(BHI, 2, DMAX);
        run_cfg(BHI + 1, 2, DMAX);
        run_cfg(200, 3, DMAX);

        // R4: blanking clamps
        run_cfg(10, 0, DMAX);
        run_cfg(10, 50, DMAX);

        // R5: partial duty
        run_cfg(12, 2, 3);
        run_cfg(12, 2, 7);

        // R9: out-of-range writes leave every pattern untouched
        wr_dig(N, 8'hFF);
        wr_dig(9, 8'hFF);
        wr_dig((1 << AW) - 1, 8'hFF);
        run_cfg(12, 3, DMAX);

        // R7: change everything while digit 0 is lit
        wait_rise(0);
        t_prev    = cyc_s;
        have_prev = 1;
        new_pats();
        for (int k = 0; k < N; k++) wr_dig(k, pat_new[k]);
        slot_len_i  = CW'(14);
        blank_len_i = CW'(4);
        dim_i       = DW'(10);
        for (int k = 1; k < N; k++) measure_slot(k, 12, 3, 9, pat_exp[k], 1'b1);
        for (int k = 0; k < N; k++) pat_exp[k] = pat_new[k];
        have_prev = 0;
        for (int k = 0; k < N; k++) measure_slot(k, 14, 4, f_on(14, 4, 10), pat_exp[k], k > 0);

        // R5: dim zero keeps every grid dark
        slot_len_i  = CW'(12);
        blank_len_i = CW'(3);
        dim_i       = '0;
        repeat (2 * N * 14 * PRE) step();
        cnt = 0;
        repeat (3 * N * 12 * PRE) begin
            step();
            if (grid_s != '0) cnt++;
        end
        check_eq("R5", "lit cycles at dim zero", cnt, 0);

        // Constrained random configurations
        for (int i = 0; i < 10; i++) begin
            int s, b, d, es;
            s = 2 + int'($urandom % 99);
            b = int'($urandom % (s + 3));
            d = 1 + int'($urandom % DMAX);
            es = f_slot(s);
            if (f_on(es, f_blank(b, es), d) == 0) d = DMAX;
            if (i % 2 == 0) begin
                new_pats();
                load_pats();
            end
            run_cfg(s, b, d);
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule